// File: doc/BRIEF.md
# PAL Field Sync Sequencer

This block lays out the vertical structure of one non-interlaced monochrome PAL-style frame on a single active-low composite sync output. It runs from a 24 MHz clock and divides time into half-line slots of 32 us (768 cycles). A frame is a numbered run of slots: ten broad-pulse slots, ten equalising-pulse slots, one picture phase, then fourteen trailing equalising-pulse slots. After the last trailing slot the frame starts again.

During the picture phase the sequencer releases sync high, raises a picture enable and waits. An external active-line engine draws the visible lines and pulses `lineDoneAll` when it is done. On the next cycle the first trailing equalising pulse begins, with no idle gap. A one-cycle `frameStart` strobe marks the first cycle of every frame so that a scope can trigger on it.

Top module: `pal_field_sync`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, `syncN` is 1 and `pictureEn` and `frameStart` are 0. The sequence then begins at slot 0, cycle 0.
- R2: Slots 0 to 9 are broad slots, each 768 cycles long. In each one `syncN` is 0 for the first 720 cycles and 1 for the last 48.
- R3: Slots 10 to 19 and 21 to 34 are equalising slots, each 768 cycles long. In each one `syncN` is 0 for the first 48 cycles and 1 for the last 720.
- R4: When slot 34 ends, slot 0 of the next frame begins on the following cycle.
- R5: Slot 20 is the picture phase. It begins on the cycle after slot 19 ends. Throughout it `pictureEn` is 1 and `syncN` is 1, for as long as `lineDoneAll` is sampled low.
- R6: When `lineDoneAll` is sampled high during the picture phase, the next cycle is cycle 0 of slot 21. In that cycle `pictureEn` is 0 and `syncN` is 0.
- R7: `frameStart` is 1 for exactly the first cycle of slot 0, in every frame including the first after reset, and is 0 at all other times.
- R8: `lineDoneAll` has no effect outside the picture phase: slot timing and outputs are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 24 MHz clock |
| rst | input | 1 | Synchronous reset, active high |
| lineDoneAll | input | 1 | The line engine has finished all picture lines |
| syncN | output | 1 | Composite sync, low during a sync pulse |
| pictureEn | output | 1 | High during the picture phase |
| frameStart | output | 1 | One-cycle strobe at the start of each frame |

## Verification
On every cycle the checker enforces the following:
- Sync stays high while the picture enable is up.
- The picture enable holds until the done input arrives, then drops with sync going low on the next cycle.
- The frame strobe lasts one cycle and coincides with a low sync.
- Every low pulse lasts either the broad or the equalising width.
- Reset forces the idle levels.

Only the bench's cycle-accurate model can show the rest:
- The order of slots within a frame, and that broad and equalising pulses fall in their numbered positions.
- That there are exactly fourteen trailing equalising slots.
- That noise on the done input outside the picture phase changes nothing.

// File: rtl/pal_sync_pkg.sv
package pal_sync_pkg;
  // Strobes from the slot-sequencing control to the slot timer datapath.
  typedef struct packed {
    logic armed;     // sequence running (first cycle after reset is idle)
    logic run;       // advance the in-slot cycle counter
    logic clear;     // hold the in-slot counter at zero
    logic longSlot;  // current slot carries a broad pulse
    logic picture;   // picture phase: sync released high
  } seqStrobe_t;
endpackage

// File: rtl/pal_slot_timer.sv
module pal_slot_timer
  import pal_sync_pkg::*;
#(
  parameter int SLOT_CYCLES = 768,
  parameter int LONG_LOW    = 720,
  parameter int SHORT_LOW   = 48
) (
  input  logic       clk,
  input  logic       rst,
  input  seqStrobe_t cmd,
  output logic       slotFirst,
  output logic       slotLast,
  output logic       syncN
);
  localparam int CW = $clog2(SLOT_CYCLES);
  localparam logic [CW-1:0] LAST_CNT  = CW'(SLOT_CYCLES - 1);
  localparam logic [CW-1:0] LONG_CNT  = CW'(LONG_LOW);
  localparam logic [CW-1:0] SHORT_CNT = CW'(SHORT_LOW);

  logic [CW-1:0] slotCnt;
  logic [CW-1:0] lowLen;

  assign slotFirst = (slotCnt == '0);
  assign slotLast  = (slotCnt == LAST_CNT);
  assign lowLen    = cmd.longSlot ? LONG_CNT : SHORT_CNT;

  always_ff @(posedge clk) begin
    if (rst || cmd.clear) begin
      slotCnt <= '0;
    end else if (cmd.run) begin
      slotCnt <= slotLast ? '0 : slotCnt + 1'b1;
    end
  end

  // Each pulse opens the slot: low from cycle 0 up to lowLen-1.
  always_comb begin
    if (!cmd.armed || cmd.picture) begin
      syncN = 1'b1;
    end else begin
      syncN = (slotCnt >= lowLen);
    end
  end
endmodule

// File: rtl/pal_field_ctrl.sv
module pal_field_ctrl
  import pal_sync_pkg::*;
#(
  parameter int NUM_LONG        = 10,
  parameter int NUM_SHORT_LEAD  = 10,
  parameter int NUM_SHORT_TRAIL = 14
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       lineDoneAll,
  input  logic       slotFirst,
  input  logic       slotLast,
  output seqStrobe_t cmd,
  output logic       pictureEn,
  output logic       frameStart
);
  localparam int PICTURE_SLOT = NUM_LONG + NUM_SHORT_LEAD;
  localparam int WRAP_SLOT    = PICTURE_SLOT + 1 + NUM_SHORT_TRAIL;
  localparam int SW           = $clog2(WRAP_SLOT + 1);
  localparam logic [SW-1:0] PIC_NUM  = SW'(PICTURE_SLOT);
  localparam logic [SW-1:0] AFTER    = SW'(PICTURE_SLOT + 1);
  localparam logic [SW-1:0] LAST_NUM = SW'(WRAP_SLOT - 1);
  localparam logic [SW-1:0] LONG_END = SW'(NUM_LONG);

  logic          armed;
  logic [SW-1:0] slotNum;
  logic          inPicture;

  assign inPicture = armed && (slotNum == PIC_NUM);

  always_ff @(posedge clk) begin
    if (rst) begin
      armed   <= 1'b0;
      slotNum <= '0;
    end else if (!armed) begin
      armed <= 1'b1;
    end else if (slotNum > LAST_NUM) begin
      slotNum <= '0;                      // any stray value restarts the frame
    end else if (inPicture) begin
      if (lineDoneAll) slotNum <= AFTER;  // first trailing slot starts next cycle
    end else if (slotLast) begin
      slotNum <= (slotNum == LAST_NUM) ? '0 : slotNum + 1'b1;
    end
  end

  always_comb begin
    cmd.armed    = armed;
    cmd.picture  = inPicture;
    cmd.run      = armed && !inPicture;
    cmd.clear    = inPicture;
    cmd.longSlot = (slotNum < LONG_END);
  end

  assign pictureEn  = inPicture;
  assign frameStart = armed && (slotNum == '0) && slotFirst;
endmodule

// File: rtl/pal_field_sync.sv
module pal_field_sync
  import pal_sync_pkg::*;
#(
  parameter int SLOT_CYCLES     = 768,
  parameter int LONG_LOW        = 720,
  parameter int SHORT_LOW       = 48,
  parameter int NUM_LONG        = 10,
  parameter int NUM_SHORT_LEAD  = 10,
  parameter int NUM_SHORT_TRAIL = 14
) (
  input  logic clk,
  input  logic rst,
  input  logic lineDoneAll,
  output logic syncN,
  output logic pictureEn,
  output logic frameStart
);
  seqStrobe_t cmd;
  logic       slotFirst;
  logic       slotLast;

  pal_field_ctrl #(
    .NUM_LONG       (NUM_LONG),
    .NUM_SHORT_LEAD (NUM_SHORT_LEAD),
    .NUM_SHORT_TRAIL(NUM_SHORT_TRAIL)
  ) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .lineDoneAll(lineDoneAll),
    .slotFirst  (slotFirst),
    .slotLast   (slotLast),
    .cmd        (cmd),
    .pictureEn  (pictureEn),
    .frameStart (frameStart)
  );

  pal_slot_timer #(
    .SLOT_CYCLES(SLOT_CYCLES),
    .LONG_LOW   (LONG_LOW),
    .SHORT_LOW  (SHORT_LOW)
  ) u_timer (
    .clk      (clk),
    .rst      (rst),
    .cmd      (cmd),
    .slotFirst(slotFirst),
    .slotLast (slotLast),
    .syncN    (syncN)
  );
endmodule

// File: rtl/pal_field_sync_chk.sv
module pal_field_sync_chk #(
  parameter int LONG_LOW  = 720,
  parameter int SHORT_LOW = 48
) (
  input logic clk,
  input logic rst,
  input logic lineDoneAll,
  input logic syncN,
  input logic pictureEn,
  input logic frameStart
);
  int lowRun;

  always_ff @(posedge clk) begin
    if (rst)         lowRun <= 0;
    else if (!syncN) lowRun <= lowRun + 1;
    else             lowRun <= 0;
  end

  a_r1_reset_idle: assert property (@(posedge clk)
    rst |=> (syncN && !pictureEn && !frameStart));

  a_r2_r3_pulse_width: assert property (@(posedge clk) disable iff (rst)
    $rose(syncN) |-> (lowRun == LONG_LOW || lowRun == SHORT_LOW));

  a_r5_picture_sync_high: assert property (@(posedge clk) disable iff (rst)
    pictureEn |-> syncN);

  a_r5_picture_hold: assert property (@(posedge clk) disable iff (rst)
    (pictureEn && !lineDoneAll) |=> pictureEn);

  a_r6_picture_release: assert property (@(posedge clk) disable iff (rst)
    (pictureEn && lineDoneAll) |=> (!pictureEn && !syncN));

  a_r7_single_strobe: assert property (@(posedge clk) disable iff (rst)
    frameStart |=> !frameStart);

  a_r7_strobe_in_pulse: assert property (@(posedge clk) disable iff (rst)
    frameStart |-> (!syncN && !pictureEn));
endmodule

bind pal_field_sync pal_field_sync_chk #(
  .LONG_LOW (LONG_LOW),
  .SHORT_LOW(SHORT_LOW)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .lineDoneAll(lineDoneAll),
  .syncN      (syncN),
  .pictureEn  (pictureEn),
  .frameStart (frameStart)
);

// File: tb/test_pal_field_sync.sv
module test_pal_field_sync;
  localparam int SLOT   = 768;
  localparam int LLOW   = 720;
  localparam int SLOW   = 48;
  localparam int PIC    = 20;
  localparam int WRAP   = 35;
  localparam int LIMIT  = 180000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic lineDoneAll = 1'b0;
  logic syncN, pictureEn, frameStart;

  always #10 clk = ~clk;

  pal_field_sync i_pal_field_sync (
    .clk(clk), .rst(rst), .lineDoneAll(lineDoneAll),
    .syncN(syncN), .pictureEn(pictureEn), .frameStart(frameStart)
  );

  int vectors = 0;
  int errors  = 0;

  // bench reference state
  bit mArmed = 0;
  int mSt = 0;
  int mCnt = 0;
  int frames = 0;
  int picWait = 0;
  bit lastNoise = 0;
  int resetAt = -1;

  function automatic logic expSync(bit armed, int st, int cnt);
    if (!armed || st == PIC) return 1'b1;
    if (st < 10) return (cnt >= LLOW);   // R2 broad slot
    return (cnt >= SLOW);                // R3 equalising slot
  endfunction

  function automatic string tagFor(bit armed, int st, int cnt, int fr, bit noise);
    if (!armed) return "R1";
    if (st == PIC) return "R5";
    if (st == PIC + 1 && cnt == 0) return "R6";
    if (st == 0 && cnt == 0) return (fr > 0) ? "R4/R7" : "R7";
    if (noise) return "R8";
    if (st < 10) return "R2";
    return "R3";
  endfunction

  function automatic int pickWait(int fr);
    case (fr)
      0: return 0;                        // done on first picture cycle
      1: return $urandom_range(3000, 1);
      2: return 1;
      default: return $urandom_range(500, 0);
    endcase
  endfunction

  task automatic checkBit(string tag, string what, logic act, logic exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0b expected=%0b (slot %0d cycle %0d)",
               tag, what, act, exp, mSt, mCnt);
    end
  endtask

  initial begin
    repeat (195000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not finish");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    string tag;
    bit    noise;
    void'($urandom(32'd20250117));
    for (int cyc = 0; cyc < LIMIT; cyc++) begin
      @(negedge clk);
      tag = tagFor(mArmed, mSt, mCnt, frames, lastNoise);
      checkBit(tag, "syncN", syncN, expSync(mArmed, mSt, mCnt));
      checkBit(tag, "pictureEn", pictureEn, logic'(mArmed && mSt == PIC));
      checkBit(tag, "frameStart", frameStart, logic'(mArmed && mSt == 0 && mCnt == 0));
      if (mArmed && mSt == 0 && mCnt == 0) begin
        frames++;
        if (frames == 5 && resetAt < 0) resetAt = cyc + 3000 + $urandom_range(5000, 0);
      end
      if (resetAt >= 0 && cyc > resetAt + 30000) break;

      // drive this cycle's inputs
      rst = (cyc < 5) || (resetAt >= 0 && cyc >= resetAt && cyc < resetAt + 3);
      noise = 1'b0;
      if (mArmed && mSt == PIC) begin
        lineDoneAll = (picWait == 0);
        if (picWait > 0) picWait--;
      end else begin
        noise = ($urandom_range(3, 0) == 0);   // R8 stray done pulses
        lineDoneAll = noise;
      end

      // reference next state
      if (rst) begin
        mArmed = 0; mSt = 0; mCnt = 0;
      end else if (!mArmed) begin
        mArmed = 1;
      end else if (mSt == PIC) begin
        if (lineDoneAll) begin mSt = PIC + 1; mCnt = 0; end
      end else if (mCnt == SLOT - 1) begin
        mCnt = 0;
        mSt = (mSt + 1 == WRAP) ? 0 : mSt + 1;
        if (mSt == PIC) picWait = pickWait(frames - 1);
      end else begin
        mCnt++;
      end
      lastNoise = noise && mArmed && !rst;
    end
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule